// File: doc/BRIEF.md
# Two-State Subset-Partitioned 4-PAM Sequence Detector

The detector turns a stream of quantized, equalized samples into four-level symbol decisions on a channel that still carries two post-cursor interference terms. Instead of a full trellis over the channel memory, it keeps only two states. The four amplitudes are split into two interleaved subsets, and the state is the subset of the previous symbol. Inside a subset, the nearer of the two parallel levels is chosen before add-compare-select. Each surviving path carries its own last two decisions. Those decisions, weighted by the two programmed taps, are removed from the sample before that path's branch costs are formed.

The work is done in independent blocks. A block is a programmable number of warm-up samples followed by a fixed number of payload samples. The upstream logic supplies the warm-up samples, normally a repeat of the tail of the preceding data. Decisions for warm-up samples are computed but never presented. At the start of every block the path metrics are cleared and the feedback history counts as zero. After the last sample of a block, the detector stalls its input while it drains the symbols still held in the survivor registers. Settings can be written only while no block is in progress.

Top module: `rsvd_detector`

## Requirements
- R1: Each decision is a 2-bit Gray code: level -3 is 00, -1 is 01, +1 is 11 and +3 is 10. Subset A is {-3,+1} and subset B is {-1,+3}, so the subset is the XOR of the two code bits. Samples are LVL times the level plus interference plus noise. With no interference and noise of at most 2, every payload decision matches the sent symbol.
- R2: With tap values h1 and h2 whose magnitudes sum to at most 9, each path subtracts h1 and h2 times its own two previous decisions from the sample. Under noise of at most 2, all payload decisions after a warm-up of 12 or more samples are error-free.
- R3: A block emits exactly BLK_LEN decisions, one per payload sample, in sample order. Decisions for the warm-up samples are never emitted.
- R4: A warm-up length of zero is legal. In that case every sample of the block yields an emitted decision.
- R5: After the final sample of a block is accepted, in_ready stays low for exactly DEPTH-1 cycles while the held decisions are drained. It then returns high for the next block.
- R6: The register port decodes address 0 as h1, address 1 as h2 (both signed, HW bits) and address 2 as the warm-up length. A write takes effect only while no block is in progress. A write during a block is dropped and is not applied later.
- R7: A sample is consumed only in a cycle where in_valid and in_ready are both high. Idle gaps inside a block do not change the decisions.
- R8: During and right after reset, in_ready is high and out_valid is low.
- R9: Path metrics are unsigned PMW-bit values with saturating addition. After each consumed sample, the smaller of the two metrics is zero. Long blocks therefore decode without metric wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 h1, 1 h2, 2 warm-up length |
| cfg_wdata | input | max(HW,SYNCW) | Register write value |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Detector can take a sample |
| in_sample | input | SW | Signed equalized sample |
| out_valid | output | 1 | A payload decision is on out_sym |
| out_sym | output | 2 | Gray-coded symbol decision |

## Verification
Some properties hold on every cycle and are checked as assertions:
- after each consumed sample, one path metric is zero;
- the tap registers hold still while a block runs;
- no decision appears right after a block's first sample;
- the input stall never exceeds DEPTH-1 cycles;
- every decision follows either a consumed sample or a drain cycle.

Other behaviours depend on a whole block and are shown only by the directed scenarios:
- the decisions equal a pseudo-random symbol sequence sent through a two-tap channel;
- warm-up decisions are suppressed, so each block yields exactly BLK_LEN decisions;
- a warm-up length of zero works;
- a tap write made mid-block is dropped.

// File: rtl/rsvd_pkg.sv
package rsvd_pkg;

   typedef logic [1:0] sym_t;

   localparam sym_t SYM_M3 = 2'b00;
   localparam sym_t SYM_M1 = 2'b01;
   localparam sym_t SYM_P1 = 2'b11;
   localparam sym_t SYM_P3 = 2'b10;

   typedef enum logic {ST_RUN = 1'b0, ST_DRAIN = 1'b1} phase_t;

   // amplitude of a Gray-coded symbol
   function automatic logic signed [2:0] sym_amp(input sym_t s);
      case (s)
         SYM_M3:  return 3'sb101;
         SYM_M1:  return 3'sb111;
         SYM_P1:  return 3'sb001;
         default: return 3'sb011;
      endcase
   endfunction

endpackage

// File: rtl/rsvd_branch.sv
// Branch unit: cancels one path's interference, chooses the nearer level of
// one subset and returns its squared error, clipped to the metric width.
module rsvd_branch
   import rsvd_pkg::*;
#(
   parameter int SW  = 10,
   parameter int HW  = 6,
   parameter int LVL = 16,
   parameter int PMW = 12,
   parameter int SUB = 0
) (
   input  logic signed [SW-1:0] sample,
   input  logic signed [HW-1:0] tap1,
   input  logic signed [HW-1:0] tap2,
   input  sym_t                 past1,
   input  sym_t                 past2,
   input  logic                 past1_ok,
   input  logic                 past2_ok,
   output sym_t                 pick,
   output logic [PMW-1:0]       cost
);
   localparam int PW = HW + 3;
   localparam int RW = ((SW > PW + 1) ? SW : PW + 1) + 2;
   localparam int DW = RW + 1;
   localparam int QW = 2 * DW;

   logic signed [PW-1:0] isi1, isi2;
   logic signed [RW-1:0] resid;
   logic signed [DW-1:0] err;
   logic        [QW-1:0] sq;

   always_comb begin
      isi1  = past1_ok ? PW'(tap1) * PW'(sym_amp(past1)) : '0;
      isi2  = past2_ok ? PW'(tap2) * PW'(sym_amp(past2)) : '0;
      resid = RW'(sample) - RW'(isi1) - RW'(isi2);
   end

   generate
      if (SUB == 0) begin : g_sub_a
         assign pick = (resid < RW'(-LVL)) ? SYM_M3 : SYM_P1;
      end else begin : g_sub_b
         assign pick = (resid < RW'(LVL)) ? SYM_M1 : SYM_P3;
      end
   endgenerate

   always_comb begin
      err  = DW'(resid) - DW'(sym_amp(pick)) * DW'(LVL);
      sq   = QW'(err) * QW'(err);
      cost = (sq > QW'(2**PMW - 1)) ? '1 : sq[PMW-1:0];
   end

endmodule

// File: rtl/rsvd_acs.sv
// Add-compare-select for one state with saturating sums.
module rsvd_acs #(
   parameter int PMW = 12
) (
   input  logic [PMW-1:0] m0,
   input  logic [PMW-1:0] m1,
   input  logic [PMW-1:0] c0,
   input  logic [PMW-1:0] c1,
   output logic           sel,
   output logic [PMW-1:0] sum
);
   logic [PMW:0] s0, s1, win;

   always_comb begin
      s0  = {1'b0, m0} + {1'b0, c0};
      s1  = {1'b0, m1} + {1'b0, c1};
      sel = (s1 < s0);
      win = sel ? s1 : s0;
      sum = win[PMW] ? '1 : win[PMW-1:0];
   end

endmodule

// File: rtl/rsvd_detector.sv
module rsvd_detector
   import rsvd_pkg::*;
#(
   parameter int SW      = 10,
   parameter int HW      = 6,
   parameter int LVL     = 16,
   parameter int PMW     = 12,
   parameter int DEPTH   = 16,
   parameter int BLK_LEN = 64,
   parameter int SYNCW   = 6,
   localparam int CFGW   = (HW > SYNCW) ? HW : SYNCW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_addr,
   input  logic [CFGW-1:0]      cfg_wdata,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic signed [SW-1:0] in_sample,
   output logic                 out_valid,
   output logic [1:0]           out_sym
);
   localparam int CNTW = $clog2(BLK_LEN + 2**SYNCW) + 1;
   localparam int FCW  = $clog2(DEPTH);

   generate
      if (DEPTH < 3)          begin : g_bad_depth $error("DEPTH must be at least 3");   end
      if (BLK_LEN < DEPTH)    begin : g_bad_blk   $error("BLK_LEN must be >= DEPTH");   end
      if (PMW < 8)            begin : g_bad_pmw   $error("PMW must be at least 8");     end
   endgenerate

   phase_t                phase;
   logic [CNTW-1:0]       in_cnt, out_idx;
   logic [FCW-1:0]        fl_cnt, fl_idx;
   logic signed [HW-1:0]  tap1_q, tap2_q;
   logic [SYNCW-1:0]      sync_q;
   logic [PMW-1:0]        pm_q [2];
   logic [PMW-1:0]        pm_n [2];
   sym_t                  surv_q [2][DEPTH];
   sym_t                  surv_n [2][DEPTH];

   sym_t                  pick_w [2][2];
   logic [PMW-1:0]        cost_w [2][2];
   logic                  sel_w  [2];
   logic [PMW-1:0]        acc_w  [2];

   logic accept, idle, last_in, best_new, best_old, emit;
   sym_t emit_sym;
   logic [PMW-1:0] pm_min;

   assign in_ready = (phase == ST_RUN);
   assign accept   = in_valid && in_ready;
   assign idle     = (phase == ST_RUN) && (in_cnt == '0);
   assign last_in  = (in_cnt == CNTW'(BLK_LEN) + CNTW'(sync_q) - CNTW'(1));

   // branch units: one per (predecessor path, subset of the new symbol)
   generate
      for (genvar p = 0; p < 2; p++) begin : g_pred
         for (genvar s = 0; s < 2; s++) begin : g_sub
            rsvd_branch #(.SW(SW), .HW(HW), .LVL(LVL), .PMW(PMW), .SUB(s)) u_br (
               .sample  (in_sample),
               .tap1    (tap1_q),
               .tap2    (tap2_q),
               .past1   (surv_q[p][0]),
               .past2   (surv_q[p][1]),
               .past1_ok(in_cnt != '0),
               .past2_ok(in_cnt > CNTW'(1)),
               .pick    (pick_w[p][s]),
               .cost    (cost_w[p][s])
            );
         end
      end
      for (genvar s = 0; s < 2; s++) begin : g_state
         rsvd_acs #(.PMW(PMW)) u_acs (
            .m0 (pm_q[0]),
            .m1 (pm_q[1]),
            .c0 (cost_w[0][s]),
            .c1 (cost_w[1][s]),
            .sel(sel_w[s]),
            .sum(acc_w[s])
         );
      end
   endgenerate

   // renormalization and register-exchange update
   always_comb begin
      best_new = (acc_w[1] < acc_w[0]);
      pm_min   = best_new ? acc_w[1] : acc_w[0];
      for (int s = 0; s < 2; s++) begin
         pm_n[s]      = acc_w[s] - pm_min;
         surv_n[s][0] = pick_w[sel_w[s]][s];
         for (int i = 1; i < DEPTH; i++) surv_n[s][i] = surv_q[sel_w[s]][i-1];
      end
   end

   // decision selection: oldest entry while running, held entries while draining
   always_comb begin
      best_old = (pm_q[1] < pm_q[0]);
      fl_idx   = FCW'(DEPTH - 2) - fl_cnt;
      if (phase == ST_RUN) begin
         emit     = accept && (in_cnt >= CNTW'(DEPTH - 1));
         emit_sym = surv_n[best_new][DEPTH-1];
      end else begin
         emit     = 1'b1;
         emit_sym = surv_q[best_old][fl_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= ST_RUN;
         in_cnt    <= '0;
         out_idx   <= '0;
         fl_cnt    <= '0;
         tap1_q    <= '0;
         tap2_q    <= '0;
         sync_q    <= '0;
         out_valid <= 1'b0;
         out_sym   <= '0;
         for (int s = 0; s < 2; s++) begin
            pm_q[s] <= '0;
            for (int i = 0; i < DEPTH; i++) surv_q[s][i] <= '0;
         end
      end else begin
         if (cfg_we && idle) begin
            case (cfg_addr)
               2'd0:    tap1_q <= cfg_wdata[HW-1:0];
               2'd1:    tap2_q <= cfg_wdata[HW-1:0];
               2'd2:    sync_q <= cfg_wdata[SYNCW-1:0];
               default: ;
            endcase
         end
         out_valid <= emit && (out_idx >= CNTW'(sync_q));
         out_sym   <= emit_sym;
         if (emit) out_idx <= out_idx + CNTW'(1);
         case (phase)
            ST_RUN: begin
               if (accept) begin
                  pm_q   <= pm_n;
                  surv_q <= surv_n;
                  in_cnt <= in_cnt + CNTW'(1);
                  if (last_in) begin
                     phase  <= ST_DRAIN;
                     fl_cnt <= '0;
                  end
               end
            end
            default: begin
               fl_cnt <= fl_cnt + FCW'(1);
               if (fl_cnt == FCW'(DEPTH - 2)) begin
                  phase   <= ST_RUN;
                  in_cnt  <= '0;
                  out_idx <= '0;
                  pm_q[0] <= '0;
                  pm_q[1] <= '0;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/rsvd_checker.sv
module rsvd_checker #(
   parameter int DEPTH = 16,
   parameter int PMW   = 12,
   parameter int CNTW  = 8,
   parameter int HW    = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic [1:0]           out_sym,
   input logic [PMW-1:0]       pm0,
   input logic [PMW-1:0]       pm1,
   input logic [CNTW-1:0]      in_cnt,
   input logic signed [HW-1:0] tap1,
   input logic signed [HW-1:0] tap2
);
   localparam int STW = $clog2(DEPTH) + 1;
   logic [STW-1:0] stall_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stall_cnt <= '0;
      else if (in_ready)  stall_cnt <= '0;
      else                stall_cnt <= stall_cnt + STW'(1);
   end

   a_r9_min_metric_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (pm0 == '0 || pm1 == '0));

   a_r6_taps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cnt != '0 || !in_ready) |=> ($stable(tap1) && $stable(tap2)));

   a_r3_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_cnt == '0) |=> !out_valid);

   a_r5_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (stall_cnt < STW'(DEPTH - 1)));

   a_r7_out_source: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid || !in_ready));

   a_r1_sym_known: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$isunknown(out_sym));

endmodule

bind rsvd_detector rsvd_checker #(.DEPTH(DEPTH), .PMW(PMW), .CNTW(CNTW), .HW(HW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_sym  (out_sym),
   .pm0      (pm_q[0]),
   .pm1      (pm_q[1]),
   .in_cnt   (in_cnt),
   .tap1     (tap1_q),
   .tap2     (tap2_q)
);

// File: tb/rsvd_detector_test.sv
module rsvd_detector_test;
   localparam int SW = 10, HW = 6, LVL = 16, PMW = 12, DEPTH = 16, BLK = 64, SYNCW = 6;
   localparam int NSYM = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [5:0] cfg_wdata = '0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic signed [SW-1:0] in_sample = '0;
   logic out_valid;
   logic [1:0] out_sym;

   always #4 clk = ~clk;

   rsvd_detector #(.SW(SW), .HW(HW), .LVL(LVL), .PMW(PMW), .DEPTH(DEPTH),
                   .BLK_LEN(BLK), .SYNCW(SYNCW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
      .in_sample(in_sample), .out_valid(out_valid), .out_sym(out_sym));

   int checks = 0;
   int fails = 0;
   int amp_seq [NSYM];
   logic [1:0] got [$];

   always @(negedge clk) if (rst_n && out_valid) got.push_back(out_sym);

   function automatic int amp_of(logic [1:0] c);
      case (c)
         2'b00:   return -3;
         2'b01:   return -1;
         2'b11:   return 1;
         default: return 3;
      endcase
   endfunction

   function automatic logic [1:0] code_of(int a);
      if (a == -3) return 2'b00;
      if (a == -1) return 2'b01;
      if (a == 1)  return 2'b11;
      return 2'b10;
   endfunction

   function automatic int chan(int p, int h1, int h2);
      return LVL * amp_seq[p] + h1 * amp_seq[p-1] + h2 * amp_seq[p-2] + ((p * 7 + 3) % 5) - 2;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(logic [1:0] a, int v);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 6'(v);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // sends warm-up plus payload, measures the drain stall, compares decisions
   task automatic run_block(int p0, int sync, int h1, int h2, int gap_at, int poke_at, string req);
      int stall = 0;
      int errs = 0;
      got.delete();
      for (int i = -sync; i < BLK; i++) begin
         @(negedge clk);
         cfg_we = 1'b0;
         if (i == gap_at) begin
            in_valid = 1'b0;
            repeat (3) @(negedge clk);
         end
         while (!in_ready) @(negedge clk);
         in_valid  = 1'b1;
         in_sample = SW'(chan(p0 + i, h1, h2));
         if (i == poke_at) begin
            cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 6'b101100;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we   = 1'b0;
      while (!in_ready) begin
         stall++;
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      check(stall == DEPTH - 1, "R5", {req, " drain stall cycles"}, stall, DEPTH - 1);
      check(got.size() == BLK, "R3", {req, " decisions per block"}, got.size(), BLK);
      for (int k = 0; k < BLK && k < got.size(); k++) begin
         if (got[k] !== code_of(amp_seq[p0 + k])) begin
            if (errs == 0)
               $display("FAIL %s first wrong decision at %0d actual=%0d expected=%0d",
                        req, k, got[k], code_of(amp_seq[p0 + k]));
            errs++;
         end
      end
      check(errs == 0, req, "symbol errors", errs, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(in_ready == 1'b1, "R8", "in_ready in reset", in_ready, 1);
      check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1 && out_valid == 1'b0, "R8", "after reset ready&!valid",
            {in_ready, out_valid}, 2);
   endtask

   task automatic t_taps_a;
      cfg_write(2'd0, 6); cfg_write(2'd1, -3); cfg_write(2'd2, 16);
      run_block(32, 16, 6, -3, 1000, 1000, "R2 R1 taps 6,-3");
   endtask

   task automatic t_taps_b_gap;
      cfg_write(2'd0, -5); cfg_write(2'd1, 4); cfg_write(2'd2, 12);
      run_block(96, 12, -5, 4, 20, 1000, "R7 R2 gap in block");
   endtask

   task automatic t_no_sync;
      cfg_write(2'd0, 0); cfg_write(2'd1, 0); cfg_write(2'd2, 0);
      run_block(160, 0, 0, 0, 1000, 1000, "R4 R1 zero warm-up");
   endtask

   task automatic t_midblock_write;
      cfg_write(2'd0, 6); cfg_write(2'd1, -3); cfg_write(2'd2, 16);
      run_block(240, 16, 6, -3, 1000, 10, "R6 write during block");
   endtask

   task automatic t_taps_retained;
      cfg_write(2'd2, 20);
      run_block(320, 20, 6, -3, 1000, 1000, "R6 R9 taps kept long run");
   endtask

   initial begin
      logic [14:0] lfsr = 15'h1acd;
      for (int n = 0; n < NSYM; n++) begin
         logic [1:0] c;
         for (int b = 0; b < 2; b++) begin
            c[b] = lfsr[14] ^ lfsr[13];
            lfsr = {lfsr[13:0], c[b]};
         end
         amp_seq[n] = amp_of(c);
      end
      repeat (3) @(posedge clk);
      t_reset();
      t_taps_a();
      t_taps_b_gap();
      t_no_sync();
      t_midblock_write();
      t_taps_retained();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule